// File: doc/BRIEF.md
# Junction Lamp Controller with Output-Encoded Phase

This block sequences the lamps at a crossing between a busy main road and a quiet side road. A presence sensor reports a vehicle waiting on the side road. Two timeout flags come from an external interval timer: a long one that bounds green time and a short one that bounds caution time. The controller drives a 2-bit lamp code for each road. It also gives a one-cycle restart pulse that the timer uses to begin a new interval.

Each of the four phases shows a different lamp pair. The controller therefore keeps no separate state register. The registered lamp codes are the state, and the current phase is decoded from them every cycle. Only the next-output functions exist: two lamp codes and the restart pulse. The four phases are main green (PH_MAIN_GO), main caution (PH_MAIN_CAUTION), side green (PH_SIDE_GO) and side caution (PH_SIDE_CAUTION). A fifth decode result, PH_FAULT, covers any lamp pair that is not legal.

The transitions are named as follows. MAIN_YIELD goes from main green to main caution. MAIN_CLEAR goes from main caution to side green. SIDE_YIELD goes from side green to side caution. SIDE_CLEAR goes from side caution to main green. FAULT_RECOVER goes from any illegal pair to main green.

Top module: `junction_lamp_ctl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs load main lamp 00, side lamp 10 and restart 0.
- R2: Lamp codes are 00 = green, 01 = caution and 10 = stop. The legal pairs (main, side) are: main green (00,10), main caution (01,10), side green (10,00) and side caution (10,01).
- R3: In main green, the lamps hold and restart stays 0 unless `car_wait` and `long_done` are both 1.
- R4: In main green with `car_wait`=1 and `long_done`=1, the next clock takes MAIN_YIELD to main caution with restart 1.
- R5: In main caution, `short_done`=1 takes MAIN_CLEAR to side green with restart 1. Otherwise the lamps hold with restart 0.
- R6: In side green, `car_wait`=0 or `long_done`=1 takes SIDE_YIELD to side caution with restart 1. With `car_wait`=1 and `long_done`=0, the lamps hold with restart 0.
- R7: In side caution, `short_done`=1 takes SIDE_CLEAR to main green with restart 1. Otherwise the lamps hold with restart 0.
- R8: `timer_restart` is 1 in exactly those cycles in which the lamp pair differs from the pair of the previous cycle.
- R9: The lamp pair is always one of the four legal pairs. Any illegal pair is replaced by main green, with restart 0, on the next clock (FAULT_RECOVER).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| car_wait | input | 1 | Vehicle present on side road |
| long_done | input | 1 | Long interval elapsed |
| short_done | input | 1 | Short interval elapsed |
| timer_restart | output | 1 | One-cycle pulse on each phase change |
| main_lamp | output | 2 | Main road lamp code |
| side_lamp | output | 2 | Side road lamp code |

## Verification
The assertions assume that the three inputs are synchronous to `clk` and are never unknown. They make no assumption about how the two timeout flags are ordered or spaced, so any combination may appear in any cycle. The stimulus changes the inputs only at the falling edge, with independent random values. Because every combination can occur in every phase, each transition and each hold condition is exercised many times.

// File: rtl/junction_pkg.sv
package junction_pkg;

    localparam int LAMP_W = 2;

    typedef enum logic [LAMP_W-1:0] {
        LAMP_GO      = 2'b00,
        LAMP_CAUTION = 2'b01,
        LAMP_STOP    = 2'b10
    } lamp_e;

    typedef enum logic [2:0] {
        PH_MAIN_GO,
        PH_MAIN_CAUTION,
        PH_SIDE_GO,
        PH_SIDE_CAUTION,
        PH_FAULT
    } phase_e;

endpackage

// File: rtl/junction_phase_decode.sv
module junction_phase_decode
    import junction_pkg::*;
(
    input  logic [LAMP_W-1:0] main_q,
    input  logic [LAMP_W-1:0] side_q,
    output phase_e            phase
);
    localparam int PAIR_W = 2 * LAMP_W;

    logic [PAIR_W-1:0] pair;
    assign pair = {main_q, side_q};

    always_comb begin
        unique case (pair)
            {LAMP_GO,      LAMP_STOP}:    phase = PH_MAIN_GO;
            {LAMP_CAUTION, LAMP_STOP}:    phase = PH_MAIN_CAUTION;
            {LAMP_STOP,    LAMP_GO}:      phase = PH_SIDE_GO;
            {LAMP_STOP,    LAMP_CAUTION}: phase = PH_SIDE_CAUTION;
            default:                      phase = PH_FAULT;
        endcase
    end
endmodule

// File: rtl/junction_next_lamps.sv
module junction_next_lamps
    import junction_pkg::*;
(
    input  phase_e            phase,
    input  logic              car_wait,
    input  logic              long_done,
    input  logic              short_done,
    input  logic [LAMP_W-1:0] main_q,
    input  logic [LAMP_W-1:0] side_q,
    output logic [LAMP_W-1:0] main_d,
    output logic [LAMP_W-1:0] side_d,
    output logic              restart_d
);
    always_comb begin
        main_d    = main_q;
        side_d    = side_q;
        restart_d = 1'b0;
        unique case (phase)
            PH_MAIN_GO: begin
                if (car_wait && long_done) begin           // MAIN_YIELD
                    main_d    = LAMP_CAUTION;
                    side_d    = LAMP_STOP;
                    restart_d = 1'b1;
                end
            end
            PH_MAIN_CAUTION: begin
                if (short_done) begin                      // MAIN_CLEAR
                    main_d    = LAMP_STOP;
                    side_d    = LAMP_GO;
                    restart_d = 1'b1;
                end
            end
            PH_SIDE_GO: begin
                if (!car_wait || long_done) begin          // SIDE_YIELD
                    main_d    = LAMP_STOP;
                    side_d    = LAMP_CAUTION;
                    restart_d = 1'b1;
                end
            end
            PH_SIDE_CAUTION: begin
                if (short_done) begin                      // SIDE_CLEAR
                    main_d    = LAMP_GO;
                    side_d    = LAMP_STOP;
                    restart_d = 1'b1;
                end
            end
            default: begin                                 // FAULT_RECOVER
                main_d    = LAMP_GO;
                side_d    = LAMP_STOP;
                restart_d = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/junction_lamp_ctl.sv
module junction_lamp_ctl
    import junction_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       car_wait,
    input  logic       long_done,
    input  logic       short_done,
    output logic       timer_restart,
    output logic [1:0] main_lamp,
    output logic [1:0] side_lamp
);
    logic [LAMP_W-1:0] main_q, side_q, main_d, side_d;
    logic              restart_q, restart_d;
    phase_e            phase;

    junction_phase_decode u_decode (
        .main_q (main_q),
        .side_q (side_q),
        .phase  (phase)
    );

    junction_next_lamps u_next (
        .phase      (phase),
        .car_wait   (car_wait),
        .long_done  (long_done),
        .short_done (short_done),
        .main_q     (main_q),
        .side_q     (side_q),
        .main_d     (main_d),
        .side_d     (side_d),
        .restart_d  (restart_d)
    );

    // Lamp registers double as the phase register.
    always_ff @(posedge clk) begin
        if (rst) begin
            main_q <= LAMP_GO;
            side_q <= LAMP_STOP;
        end else begin
            main_q <= main_d;
            side_q <= side_d;
        end
    end

    // Timer restart pulse register.
    always_ff @(posedge clk) begin
        if (rst) restart_q <= 1'b0;
        else     restart_q <= restart_d;
    end

    assign main_lamp     = main_q;
    assign side_lamp     = side_q;
    assign timer_restart = restart_q;

    AST_RESET_LOAD: assert property (@(posedge clk)
        rst |=> (main_lamp == 2'b00 && side_lamp == 2'b10 && !timer_restart)); // R1
    AST_LEGAL_PAIR: assert property (@(posedge clk) disable iff (rst)
        ({main_lamp, side_lamp} inside {4'b0010, 4'b0110, 4'b1000, 4'b1001})); // R9
    AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (main_lamp == 2'b00 && side_lamp == 2'b10 && !(car_wait && long_done))
        |=> ($stable(main_lamp) && $stable(side_lamp) && !timer_restart)); // R3
    AST_MAIN_YIELD: assert property (@(posedge clk) disable iff (rst)
        (main_lamp == 2'b00 && side_lamp == 2'b10 && car_wait && long_done)
        |=> (main_lamp == 2'b01 && side_lamp == 2'b10 && timer_restart)); // R4
    AST_MAIN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (main_lamp == 2'b01 && side_lamp == 2'b10 && short_done)
        |=> (main_lamp == 2'b10 && side_lamp == 2'b00 && timer_restart)); // R5
    AST_SIDE_YIELD: assert property (@(posedge clk) disable iff (rst)
        (main_lamp == 2'b10 && side_lamp == 2'b00 && (!car_wait || long_done))
        |=> (main_lamp == 2'b10 && side_lamp == 2'b01 && timer_restart)); // R6
    AST_SIDE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (main_lamp == 2'b10 && side_lamp == 2'b01 && short_done)
        |=> (main_lamp == 2'b00 && side_lamp == 2'b10 && timer_restart)); // R7
    AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst || $past(rst))
        timer_restart == ({main_lamp, side_lamp} != $past({main_lamp, side_lamp}))); // R8
endmodule

// File: tb/junction_lamp_ctl_tb.sv
`timescale 1ns/1ps
module junction_lamp_ctl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       car_wait = 1'b0, long_done = 1'b0, short_done = 1'b0;
    logic       timer_restart;
    logic [1:0] main_lamp, side_lamp;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    junction_lamp_ctl u_dut (
        .clk(clk), .rst(rst), .car_wait(car_wait), .long_done(long_done),
        .short_done(short_done), .timer_restart(timer_restart),
        .main_lamp(main_lamp), .side_lamp(side_lamp)
    );

    // Reference: phase 0 main green, 1 main caution, 2 side green, 3 side caution
    int  ref_phase;
    bit  ref_restart;
    string ref_tag;

    function automatic logic [3:0] pair_of(int p);
        case (p)
            0: return 4'b0010;
            1: return 4'b0110;
            2: return 4'b1000;
            default: return 4'b1001;
        endcase
    endfunction

    task automatic compare(string tag);
        logic [3:0] exp_pair;
        exp_pair = pair_of(ref_phase);
        vectors++;
        if ({main_lamp, side_lamp} !== exp_pair || timer_restart !== ref_restart) begin
            miscompares++;
            $display("FAIL %s: lamps=%b restart=%b expected lamps=%b restart=%b",
                     tag, {main_lamp, side_lamp}, timer_restart, exp_pair, ref_restart);
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        ref_phase = 0; ref_restart = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset state");
        rst = 1'b0;
        // Check reset again mid-run later; main random run first
        for (int i = 0; i < 3000; i++) begin
            logic c, l, s;
            c = 1'($urandom); l = 1'($urandom); s = 1'($urandom);
            car_wait = c; long_done = l; short_done = s;
            ref_restart = 0;
            case (ref_phase)
                0: if (c && l) begin ref_phase = 1; ref_restart = 1; ref_tag = "R4 main yield"; end
                   else ref_tag = "R3 main hold";
                1: if (s) begin ref_phase = 2; ref_restart = 1; ref_tag = "R5 main clear"; end
                   else ref_tag = "R5 main caution hold";
                2: if (!c || l) begin ref_phase = 3; ref_restart = 1; ref_tag = "R6 side yield"; end
                   else ref_tag = "R6 side hold";
                default: if (s) begin ref_phase = 0; ref_restart = 1; ref_tag = "R7 side clear"; end
                   else ref_tag = "R7 side caution hold";
            endcase
            @(negedge clk);
            compare({ref_tag, " (R2 R8 R9)"});
            if (i == 1500) begin
                rst = 1'b1;
                @(negedge clk);
                ref_phase = 0; ref_restart = 0;
                compare("R1 reset mid-run");
                rst = 1'b0;
            end
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule